// File: doc/BRIEF.md
# Gated One-Shot Pulse Generator

The block is a synchronous, non-retriggerable one-shot. A cycle counter sets the pulse length. It has two control inputs: an enable line `a_i` and a trigger line `b_i`. Either of two qualified edges starts an output pulse:

- a rising edge on the trigger line while the enable line is low;
- a falling edge on the enable line while the trigger line is high.

The pulse then lasts exactly the programmed number of clock cycles, whatever the inputs do in the meantime. How long a control line stays at its new level does not matter; only the edge counts.

Both control lines pass through a configurable synchroniser. An edge is found by comparing the newest synchronised sample with the one from the cycle before. The pulse length comes from `len_i`, which is sampled in the cycle a pulse starts. A clear input cuts any running pulse short at once and overrides a trigger that arrives in the same cycle. The output comes in true and complement form.

Top module: `os_oneshot`

## Requirements
- R1: During and after reset with no trigger, `q_o` is 0 and `qn_o` is 1, and `qn_o` is always the inverse of `q_o`.
- R2: If `b_i` goes from 0 to 1 while `a_i` is 0, `q_o` rises after the third rising clock edge that follows the input change (with the default two-stage synchroniser).
- R3: If `a_i` goes from 1 to 0 while `b_i` is 1, a pulse starts with the same latency as in R2.
- R4: A qualified edge that arrives while the pulse is high changes neither its length nor its end.
- R5: While `clr_i` is 1, `q_o` is 0 in that same cycle, and a running pulse does not resume after `clr_i` returns to 0.
- R6: If `clr_i` is 1 in the cycle a qualified edge is detected, no pulse starts from that edge.
- R7: The pulse stays high for exactly N cycles, where N is `len_i` sampled in the detection cycle and a value of 0 counts as 1. Changes to `len_i` during a pulse have no effect on it.
- R8: A trigger level held for one cycle is enough to start a pulse. A level held longer than the pulse starts only one pulse.
- R9: A qualified edge detected in the first cycle after a pulse has ended starts a new pulse.
- R10: Input levels present when reset is released start no pulse, even if they match a trigger condition.
- R11: A rising `b_i` while `a_i` is 1, a falling `a_i` while `b_i` is 0, and a falling `b_i` start no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Enable line; its falling edge triggers when `b_i` is high |
| b_i | input | 1 | Trigger line; its rising edge triggers when `a_i` is low |
| clr_i | input | 1 | Clear, active high, synchronous to `clk_i`; ends the pulse at once |
| len_i | input | CNT_W | Pulse length in cycles, sampled when a pulse starts |
| q_o | output | 1 | Pulse output |
| qn_o | output | 1 | Inverse of `q_o` |

## Verification
An input change made between edges reaches the second synchroniser stage after two rising edges. It is detected in the cycle that follows, and `q_o` goes high after the third edge. `clr_i` masks `q_o` in the same cycle. A pulse started with length N falls after N further edges. The bench drives all inputs on the falling clock edge. It updates a cycle-level model of these latencies at every rising edge and compares `q_o` and `qn_o` with that model at the next falling edge, so every check lands in the cycle where the requirement fixes the value.

// File: rtl/os_oneshot_pkg.sv
package os_oneshot_pkg;

  typedef struct packed {
    logic a;
    logic b;
  } os_ctl_t;

  // zero length is treated as one cycle
  function automatic logic [31:0] os_clamp_len(input logic [31:0] len);
    return (len == 32'd0) ? 32'd1 : len;
  endfunction

endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= '0;
        else         stg_q[i] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[i] <= '0;
        else         stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/os_trig_detect.sv
module os_trig_detect
  import os_oneshot_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  os_ctl_t cur_i,
  output logic    trig_o
);

  localparam int unsigned PRIME_N = STAGES + 1;
  localparam int unsigned PRIME_W = $clog2(PRIME_N + 1);

  os_ctl_t             prev_q;
  logic [PRIME_W-1:0]  prime_q;
  logic                armed;
  logic                b_rise;
  logic                a_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      prime_q <= '0;
    end else begin
      prev_q <= cur_i;
      if (!armed) prime_q <= prime_q + 1'b1;
    end
  end

  // edges count only once the history holds real samples
  assign armed  = (prime_q == PRIME_W'(PRIME_N));
  assign b_rise = cur_i.b & ~prev_q.b & ~cur_i.a;
  assign a_fall = ~cur_i.a & prev_q.a & cur_i.b;
  assign trig_o = armed & (b_rise | a_fall);

endmodule

// File: rtl/os_pulse_timer.sv
module os_pulse_timer
  import os_oneshot_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             active_o
);

  logic             act_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_len;

  assign load_len = CNT_W'(os_clamp_len(32'(len_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= load_len - 1'b1;
    end
  end

  assign active_o = act_q;

endmodule

// File: rtl/os_oneshot.sv
module os_oneshot
  import os_oneshot_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             q_o,
  output logic             qn_o
);

  os_ctl_t raw_ctl;
  os_ctl_t sync_ctl;
  logic    trig;
  logic    active;

  assign raw_ctl.a = a_i;
  assign raw_ctl.b = b_i;

  os_sync #(
    .W      ($bits(os_ctl_t)),
    .STAGES (STAGES)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_ctl),
    .q_o    (sync_ctl)
  );

  os_trig_detect #(
    .STAGES (STAGES)
  ) i_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (sync_ctl),
    .trig_o (trig)
  );

  os_pulse_timer #(
    .CNT_W (CNT_W)
  ) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (trig),
    .clr_i    (clr_i),
    .len_i    (len_i),
    .active_o (active)
  );

  // clear masks the output in the same cycle
  assign q_o  = active & ~clr_i;
  assign qn_o = ~q_o;

endmodule

// File: rtl/os_oneshot_chk.sv
module os_oneshot_chk
  import os_oneshot_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic [CNT_W-1:0] len_i,
  input logic             q_o,
  input logic             qn_o
);

  logic             q_d;
  logic [CNT_W-1:0] len_d;
  logic [CNT_W:0]   run_q;
  logic [CNT_W:0]   lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_d   <= 1'b0;
      len_d <= '0;
      run_q <= '0;
      lim_q <= '0;
    end else begin
      q_d   <= q_o;
      len_d <= len_i;
      run_q <= q_o ? run_q + 1'b1 : '0;
      if (q_o && !q_d) lim_q <= (CNT_W+1)'(os_clamp_len(32'(len_d)));
    end
  end

  p_comp_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qn_o == !q_o);

  p_clear_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |-> !q_o);

  p_clear_ends_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !q_o) |=> !q_o);

  p_clear_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !q_d) |-> !$past(clr_i));

  p_len_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && q_d) |-> (run_q < lim_q));

endmodule

bind os_oneshot os_oneshot_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_i  (clr_i),
  .len_i  (len_i),
  .q_o    (q_o),
  .qn_o   (qn_o)
);

// File: tb/test_os_oneshot.sv
`timescale 1ns/1ps
module test_os_oneshot;

  localparam int CNT_W  = 8;
  localparam int STAGES = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             a = 1'b0, b = 1'b0, clr = 1'b0;
  logic [CNT_W-1:0] len = 8'd4;
  logic             q, qn;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  os_oneshot #(.CNT_W(CNT_W), .STAGES(STAGES)) i_os_oneshot (
    .clk_i (clk), .rst_ni (rst_n), .a_i (a), .b_i (b), .clr_i (clr),
    .len_i (len), .q_o (q), .qn_o (qn)
  );

  // cycle-level model built from the requirements
  logic       m_sa [STAGES];
  logic       m_sb [STAGES];
  logic       m_pa, m_pb, m_act;
  int         m_prime, m_cnt;

  function automatic int clamp_len(input int l);
    return (l == 0) ? 1 : l;
  endfunction

  function automatic logic model_trig(input logic sa, input logic sb,
                                      input logic pa, input logic pb);
    return (sb && !pb && !sa) || (!sa && pa && sb);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) begin m_sa[i] = 1'b0; m_sb[i] = 1'b0; end
      m_pa = 1'b0; m_pb = 1'b0; m_act = 1'b0; m_prime = 0; m_cnt = 0;
    end else begin
      logic t;
      t = (m_prime == STAGES + 1) &&
          model_trig(m_sa[STAGES-1], m_sb[STAGES-1], m_pa, m_pb);
      if (clr) begin
        m_act = 1'b0;
      end else if (m_act) begin
        if (m_cnt == 0) m_act = 1'b0; else m_cnt = m_cnt - 1;
      end else if (t) begin
        m_act = 1'b1;
        m_cnt = clamp_len(int'(len)) - 1;
      end
      m_pa = m_sa[STAGES-1];
      m_pb = m_sb[STAGES-1];
      for (int i = STAGES - 1; i > 0; i--) begin
        m_sa[i] = m_sa[i-1]; m_sb[i] = m_sb[i-1];
      end
      m_sa[0] = a; m_sb[0] = b;
      if (m_prime < STAGES + 1) m_prime = m_prime + 1;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", req, $time, act, exp);
    end
  endtask

  // sample away from the rising edge
  always @(negedge clk) begin
    logic eq;
    eq = rst_n ? (m_act && !clr) : 1'b0;
    check(rst_n ? tag : "R1", q, eq);
    check("R1", qn, !eq);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic na, input logic nb);
    a = na; b = nb;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R10: trigger-like levels held across reset release
    tag = "R10";
    drive(1'b0, 1'b1);
    step(4);
    rst_n = 1'b1;
    step(10);

    // R11: falling b, and rising b with a high
    tag = "R11";
    drive(1'b0, 1'b0); step(6);
    drive(1'b1, 1'b0); step(4);
    drive(1'b1, 1'b1); step(6);
    drive(1'b1, 1'b0); step(3);
    drive(1'b0, 1'b0); step(6);   // falling a with b low

    // R2 + R8: rising b with a low, held far longer than the pulse
    tag = "R2"; len = 8'd5;
    drive(1'b0, 1'b1); step(6);
    tag = "R8"; step(20);
    drive(1'b0, 1'b0); step(4);
    // R8: one-cycle trigger
    drive(1'b0, 1'b1); step(1); drive(1'b0, 1'b0); step(10);

    // R3: falling a with b high
    tag = "R3"; len = 8'd3;
    drive(1'b1, 1'b1); step(6);
    drive(1'b0, 1'b1); step(10);
    drive(1'b0, 1'b0); step(4);

    // R4: retrigger during a pulse is ignored
    tag = "R4"; len = 8'd10;
    drive(1'b0, 1'b1); step(5);
    drive(1'b0, 1'b0); step(1); drive(1'b0, 1'b1); step(1);
    drive(1'b0, 1'b0); step(2); drive(1'b0, 1'b1); step(12);
    drive(1'b0, 1'b0); step(4);

    // R7: zero length and length change during a pulse
    tag = "R7"; len = 8'd0;
    drive(1'b0, 1'b1); step(1); drive(1'b0, 1'b0); step(8);
    len = 8'd6;
    drive(1'b0, 1'b1); step(4); len = 8'd1; step(10);
    drive(1'b0, 1'b0); step(4);

    // R5: clear in the middle of a pulse
    tag = "R5"; len = 8'd12;
    drive(1'b0, 1'b1); step(7);
    clr = 1'b1; step(1); clr = 1'b0; step(14);
    drive(1'b0, 1'b0); step(4);

    // R6: clear in the detection cycle
    tag = "R6"; len = 8'd4;
    drive(1'b0, 1'b1); step(2);
    clr = 1'b1; step(1); clr = 1'b0; step(10);
    drive(1'b0, 1'b0); step(4);

    // R9: trigger detected right after a one-cycle pulse ends
    tag = "R9"; len = 8'd1;
    for (int k = 0; k < 4; k++) begin
      drive(1'b0, 1'b1); step(1); drive(1'b0, 1'b0); step(1);
    end
    step(8);

    // random mix
    tag = "R7";
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 2) == 0) drive(1'($urandom), 1'($urandom));
      clr = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 7) == 0) len = CNT_W'($urandom_range(0, 9));
      step(1);
    end
    clr = 1'b0;
    step(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule